// File: doc/BRIEF.md
# Chip-Select Segment Window Decoder

This block keeps one segment register for each flash chip select. A segment register gives the lower and upper bounds of that chip select's window in the system address map. Both bounds are counted in 8 MiB units, and the upper bound is exclusive. Every write to a segment register goes through a set of checks. A write whose value equals the stored value does nothing. The start of chip select 0 is pinned to the window base. A segment that falls outside the controller's flash window is refused, and the register keeps its previous value. A misaligned segment, or one that overlaps a neighbour, is stored but flagged. Any write that is clamped, refused or flagged raises a one-cycle error strobe.

On the decode side, the block takes a qualified bus address. One cycle later it returns a one-hot chip-select hit and the byte offset of the address inside the selected segment. Where segments overlap, the lowest-numbered chip select wins. An address that falls in no segment gives no hit and pulses the same error strobe. The serial sequencing and the data path sit elsewhere. They use this block's hit and offset.

Top module: `seg_window_decoder`

## Requirements
- R1: After reset, chip select i holds the default layout: CS0 covers 8 units from the window base, and each following chip select covers 4 units, directly after the previous one. With the defaults (base 0x40 units, 5 chip selects), the registers read 0x48400000, 0x4C480000, 0x504C0000, 0x54500000 and 0x58540000.
- R2: A segment register holds the end field (exclusive, in 8 MiB units) in bits [31:24] and the start field in bits [23:16]. Bits [15:0] always read as zero, whatever was written.
- R3: A write to CS0 stores the window base in the start field, whatever start was written. If the written start differed from the base, err_o pulses in the next cycle.
- R4: A write is refused, and the register keeps its old value, when its end field is at or below the window base field or its start field is above the window end field (base plus window size). err_o pulses. A start equal to the window end field is accepted.
- R5: A write whose segment is non-empty and whose start is not a multiple of its size (end minus start) is stored, and err_o pulses.
- R6: A write whose segment [start, end) intersects another chip select's stored segment is stored, and err_o pulses.
- R7: A write whose bits [31:16] equal the stored value changes nothing and raises no error, even when the stored segment overlaps another one.
- R8: A write that lies inside the window, is aligned and overlaps nothing is stored with no error.
- R9: When addr_vld_i is high, hit_o and offset_o in the next cycle give the chip select whose segment holds the address, and the address minus that segment's start. When addr_vld_i is low, hit_o is zero in the next cycle.
- R10: When an address lies in more than one segment, hit_o selects only the lowest-numbered of them. At most one hit bit is ever set.
- R11: A qualified address that lies in no segment gives hit_o zero and offset_o zero, and err_o pulses in the next cycle.
- R12: A segment whose end is at or below its start is empty and never hits.
- R13: A write to an index at or above the number of chip selects has no effect and raises no error. A read of such an index returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Segment register write strobe |
| wr_idx_i | input | IDX_W (4) | Chip-select index of the write |
| wr_data_i | input | 32 | Write value |
| rd_idx_i | input | IDX_W (4) | Chip-select index of the read |
| rd_data_o | output | 32 | Segment register contents (combinational) |
| addr_vld_i | input | 1 | Qualifies addr_i for decoding |
| addr_i | input | ADDR_W (32) | Bus address to decode |
| hit_o | output | NUM_CS (5) | One-hot chip-select hit, registered |
| offset_o | output | ADDR_W (32) | Byte offset inside the hit segment, registered |
| err_o | output | 1 | One-cycle error strobe for bad writes and decode misses |

## Verification
A wrong segment register shows up in two ways: on the read port at once, and on the first decode that touches its range one cycle later, as a wrong hit bit or a shifted offset. Mistakes in the write checks show up as an err_o pulse that is missing or extra in the cycle after the write, or as a readback that kept or lost a value it should not have. Priority faults only show when two segments really intersect, so the stimulus sets up deliberate overlaps. It also sets up empty segments, and windows that touch edge to edge, where off-by-one comparisons would hit the wrong way.

// File: rtl/seg_pkg.sv
package seg_pkg;
   // Fixed register layout: end field [31:24], start field [23:16], [15:0] zero.
   localparam int unsigned REG_W     = 32;
   localparam int unsigned FLD_W     = 8;
   localparam int unsigned UNIT_LG   = 23;
   localparam int unsigned SEG_AW    = FLD_W + UNIT_LG;
   localparam int unsigned END_LSB   = 24;
   localparam int unsigned START_LSB = 16;

   typedef logic [FLD_W-1:0] fld_t;

   function automatic fld_t seg_end(input logic [REG_W-1:0] r);
      return r[END_LSB +: FLD_W];
   endfunction

   function automatic fld_t seg_start(input logic [REG_W-1:0] r);
      return r[START_LSB +: FLD_W];
   endfunction

   function automatic logic [REG_W-1:0] seg_pack(input fld_t e, input fld_t s);
      return {e, s, 16'h0000};
   endfunction

   // Remainder of n / d by restoring division; d must be non-zero.
   function automatic fld_t fld_mod(input fld_t n, input fld_t d);
      logic [FLD_W:0] r;
      r = '0;
      for (int i = FLD_W - 1; i >= 0; i--) begin
         r = {r[FLD_W-1:0], n[i]};
         if (r >= {1'b0, d}) r = r - {1'b0, d};
      end
      return r[FLD_W-1:0];
   endfunction
endpackage

// File: rtl/seg_wr_check.sv
module seg_wr_check
   import seg_pkg::*;
#(
   parameter int unsigned NUM_CS    = 5,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned BASE_F    = 'h40,
   parameter int unsigned WEND_F    = 'h60
) (
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [REG_W-1:0]              wr_data,
   input  logic [NUM_CS-1:0][REG_W-1:0]  seg_all,
   output logic                          apply,
   output logic [REG_W-1:0]              new_val,
   output logic                          err
);
   localparam logic [FLD_W:0] BASE9 = (FLD_W+1)'(BASE_F);
   localparam logic [FLD_W:0] WEND9 = (FLD_W+1)'(WEND_F);
   localparam fld_t           BASE8 = FLD_W'(BASE_F);

   logic             in_range, same, clamp, reject, misalign, overlap, nonempty;
   logic [REG_W-1:0] cur;
   fld_t             s_raw, s_fix, e_new, size;

   always_comb begin
      in_range = ({{(32-IDX_W){1'b0}}, wr_idx} < NUM_CS);
      cur      = '0;
      for (int i = 0; i < NUM_CS; i++)
         if (in_range && wr_idx == IDX_W'(i)) cur = seg_all[i];

      same     = (wr_data[REG_W-1:START_LSB] == cur[REG_W-1:START_LSB]);
      e_new    = seg_end(wr_data);
      s_raw    = seg_start(wr_data);
      clamp    = (wr_idx == '0) && (s_raw != BASE8);
      s_fix    = clamp ? BASE8 : s_raw;

      reject   = ({1'b0, e_new} <= BASE9) || ({1'b0, s_fix} > WEND9);
      nonempty = (e_new > s_fix);
      size     = nonempty ? (e_new - s_fix) : '0;
      misalign = nonempty && (fld_mod(s_fix, size) != '0);

      overlap  = 1'b0;
      for (int j = 0; j < NUM_CS; j++) begin
         if (wr_idx != IDX_W'(j) &&
             e_new > seg_end(seg_all[j]) - (seg_end(seg_all[j]) - seg_start(seg_all[j])) &&
             e_new > seg_start(seg_all[j]) && s_fix < seg_end(seg_all[j]))
            overlap = 1'b1;
      end

      new_val = seg_pack(e_new, s_fix);
      apply   = wr_en && in_range && !same && !reject;
      err     = wr_en && in_range && !same && (clamp || reject || misalign || overlap);
   end
endmodule

// File: rtl/seg_decode.sv
module seg_decode
   import seg_pkg::*;
#(
   parameter int unsigned NUM_CS = 5,
   parameter int unsigned ADDR_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          vld,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [NUM_CS-1:0][REG_W-1:0]  seg_all,
   output logic [NUM_CS-1:0]             hit_q,
   output logic [ADDR_W-1:0]             off_q,
   output logic                          miss_q
);
   localparam int unsigned PAD_W = ADDR_W - SEG_AW;

   logic [ADDR_W-1:0] lo_a [NUM_CS];
   logic [ADDR_W-1:0] hi_a [NUM_CS];
   logic [NUM_CS-1:0] in_seg, sel;
   logic [ADDR_W-1:0] off_n;

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
      assign lo_a[g]   = {{PAD_W{1'b0}}, seg_start(seg_all[g]), {UNIT_LG{1'b0}}};
      assign hi_a[g]   = {{PAD_W{1'b0}}, seg_end(seg_all[g]),   {UNIT_LG{1'b0}}};
      assign in_seg[g] = (addr >= lo_a[g]) && (addr < hi_a[g]);
   end

   // Lowest set bit wins.
   assign sel = in_seg & (~in_seg + NUM_CS'(1));

   always_comb begin
      off_n = '0;
      for (int i = 0; i < NUM_CS; i++)
         if (sel[i]) off_n = addr - lo_a[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q  <= '0;
         off_q  <= '0;
         miss_q <= 1'b0;
      end else begin
         hit_q  <= vld ? sel : '0;
         off_q  <= vld ? off_n : '0;
         miss_q <= vld && (sel == '0);
      end
   end
endmodule

// File: rtl/seg_window_decoder.sv
module seg_window_decoder
   import seg_pkg::*;
#(
   parameter int unsigned NUM_CS         = 5,
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned WIN_BASE_UNITS = 'h40,
   parameter int unsigned WIN_UNITS      = 'h20,
   parameter int unsigned DEF_CS0_UNITS  = 8,
   parameter int unsigned DEF_CSN_UNITS  = 4,
   localparam int unsigned IDX_W         = $clog2(NUM_CS) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [IDX_W-1:0]   wr_idx_i,
   input  logic [31:0]        wr_data_i,
   input  logic [IDX_W-1:0]   rd_idx_i,
   output logic [31:0]        rd_data_o,
   input  logic               addr_vld_i,
   input  logic [ADDR_W-1:0]  addr_i,
   output logic [NUM_CS-1:0]  hit_o,
   output logic [ADDR_W-1:0]  offset_o,
   output logic               err_o
);
   localparam int unsigned WEND_F  = WIN_BASE_UNITS + WIN_UNITS;
   localparam int unsigned DEF_TOP = WIN_BASE_UNITS + DEF_CS0_UNITS + (NUM_CS - 1) * DEF_CSN_UNITS;

   // Elaboration-time parameter checks.
   if (NUM_CS < 1 || NUM_CS > 8) begin : g_bad_ncs
      $error("NUM_CS must be 1..8");
   end
   if (ADDR_W <= SEG_AW) begin : g_bad_aw
      $error("ADDR_W must exceed the segment address width");
   end
   if (WEND_F > 255 || WIN_BASE_UNITS == 0) begin : g_bad_win
      $error("window must lie inside the 8-bit unit range");
   end
   if (DEF_TOP > 255 || DEF_CS0_UNITS == 0 || DEF_CSN_UNITS == 0) begin : g_bad_def
      $error("default layout does not fit");
   end

   logic [NUM_CS-1:0][REG_W-1:0] seg_q;
   logic [NUM_CS-1:0][REG_W-1:0] seg_rst;
   logic                         wr_apply, wr_err, wr_err_q, miss_q;
   logic [REG_W-1:0]             wr_val;

   for (genvar g = 0; g < NUM_CS; g++) begin : g_def
      if (g == 0) begin : g_first
         assign seg_rst[g] = seg_pack(FLD_W'(WIN_BASE_UNITS + DEF_CS0_UNITS),
                                      FLD_W'(WIN_BASE_UNITS));
      end else begin : g_rest
         assign seg_rst[g] = seg_pack(
            FLD_W'(WIN_BASE_UNITS + DEF_CS0_UNITS + g * DEF_CSN_UNITS),
            FLD_W'(WIN_BASE_UNITS + DEF_CS0_UNITS + (g - 1) * DEF_CSN_UNITS));
      end
   end

   seg_wr_check #(
      .NUM_CS (NUM_CS),
      .IDX_W  (IDX_W),
      .BASE_F (WIN_BASE_UNITS),
      .WEND_F (WEND_F)
   ) u_chk (
      .wr_en   (wr_en_i),
      .wr_idx  (wr_idx_i),
      .wr_data (wr_data_i),
      .seg_all (seg_q),
      .apply   (wr_apply),
      .new_val (wr_val),
      .err     (wr_err)
   );

   for (genvar g = 0; g < NUM_CS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            seg_q[g] <= seg_rst[g];
         else if (wr_apply && wr_idx_i == IDX_W'(g))
            seg_q[g] <= wr_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_err_q <= 1'b0;
      else        wr_err_q <= wr_err;
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < NUM_CS; i++)
         if (rd_idx_i == IDX_W'(i)) rd_data_o = seg_q[i];
   end

   seg_decode #(
      .NUM_CS (NUM_CS),
      .ADDR_W (ADDR_W)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (addr_vld_i),
      .addr    (addr_i),
      .seg_all (seg_q),
      .hit_q   (hit_o),
      .off_q   (offset_o),
      .miss_q  (miss_q)
   );

   assign err_o = wr_err_q | miss_q;
endmodule

// File: rtl/seg_window_sva.sv
module seg_window_sva
   import seg_pkg::*;
#(
   parameter int unsigned NUM_CS         = 5,
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned WIN_BASE_UNITS = 'h40,
   parameter int unsigned WIN_UNITS      = 'h20,
   parameter int unsigned IDX_W          = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en_i,
   input  logic [IDX_W-1:0]              wr_idx_i,
   input  logic [31:0]                   wr_data_i,
   input  logic [IDX_W-1:0]              rd_idx_i,
   input  logic [31:0]                   rd_data_o,
   input  logic                          addr_vld_i,
   input  logic [NUM_CS-1:0]             hit_o,
   input  logic                          err_o,
   input  logic [NUM_CS-1:0][REG_W-1:0]  seg_q
);
   localparam logic [8:0] BASE9 = 9'(WIN_BASE_UNITS);
   localparam logic [8:0] WEND9 = 9'(WIN_BASE_UNITS + WIN_UNITS);

   logic [REG_W-1:0] wr_cur;
   always_comb begin
      wr_cur = '0;
      for (int i = 0; i < NUM_CS; i++)
         if (wr_idx_i == IDX_W'(i)) wr_cur = seg_q[i];
   end

   assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[15:0] == 16'h0);

   assert_cs0_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_idx_i == '0 |-> rd_data_o[23:16] == BASE9[7:0]);

   for (genvar g = 0; g < NUM_CS; g++) begin : g_win
      assert_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ({1'b0, seg_q[g][31:24]} > BASE9) && ({1'b0, seg_q[g][23:16]} <= WEND9));
   end

   assert_same_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i && !addr_vld_i && ({{(32-IDX_W){1'b0}}, wr_idx_i} < NUM_CS) &&
      wr_data_i[31:16] == wr_cur[31:16] |=> !err_o && $stable(seg_q));

   assert_idle_nohit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_vld_i |=> hit_o == '0);

   assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_o));

   assert_miss_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
      addr_vld_i |=> (hit_o != '0) || err_o);
endmodule

bind seg_window_decoder seg_window_sva #(
   .NUM_CS         (NUM_CS),
   .ADDR_W         (ADDR_W),
   .WIN_BASE_UNITS (WIN_BASE_UNITS),
   .WIN_UNITS      (WIN_UNITS),
   .IDX_W          (IDX_W)
) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en_i    (wr_en_i),
   .wr_idx_i   (wr_idx_i),
   .wr_data_i  (wr_data_i),
   .rd_idx_i   (rd_idx_i),
   .rd_data_o  (rd_data_o),
   .addr_vld_i (addr_vld_i),
   .hit_o      (hit_o),
   .err_o      (err_o),
   .seg_q      (seg_q)
);

// File: tb/tb_seg_window_decoder.sv
module tb_seg_window_decoder;
   localparam int NCS = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_idx = '0;
   logic [31:0] rd_data;
   logic        vld = 1'b0;
   logic [31:0] addr = '0;
   logic [4:0]  hit;
   logic [31:0] off;
   logic        err;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   seg_window_decoder dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
      .rd_idx_i(rd_idx), .rd_data_o(rd_data),
      .addr_vld_i(vld), .addr_i(addr),
      .hit_o(hit), .offset_o(off), .err_o(err)
   );

   localparam logic [1:0] K_WR = 2'd0, K_DEC = 2'd1, K_RD = 2'd2;

   typedef struct packed {
      logic [1:0]  kind;
      logic [3:0]  req;
      logic [3:0]  idx;
      logic [31:0] data;
      logic        xerr;
      logic [4:0]  xhit;
      logic [31:0] xval;
   } vec_t;

   localparam int NV = 38;
   localparam vec_t VEC [NV] = '{
      '{K_DEC, 4'd9,  4'd0, 32'h2000_1234, 1'b0, 5'b00001, 32'h0000_1234}, // R9
      '{K_DEC, 4'd9,  4'd0, 32'h2500_0010, 1'b0, 5'b00010, 32'h0100_0010}, // R9
      '{K_DEC, 4'd9,  4'd0, 32'h2BFF_FFFC, 1'b0, 5'b10000, 32'h01FF_FFFC}, // R9
      '{K_DEC, 4'd11, 4'd0, 32'h2C00_0000, 1'b1, 5'b00000, 32'h0},         // R11
      '{K_DEC, 4'd11, 4'd0, 32'h1FFF_FFFF, 1'b1, 5'b00000, 32'h0},         // R11
      '{K_WR,  4'd8,  4'd4, 32'h6058_0000, 1'b0, 5'b0, 32'h0},             // R8
      '{K_RD,  4'd8,  4'd4, 32'h0,         1'b0, 5'b0, 32'h6058_0000},     // R8
      '{K_DEC, 4'd9,  4'd0, 32'h2C00_0100, 1'b0, 5'b10000, 32'h0000_0100}, // R9
      '{K_WR,  4'd8,  4'd3, 32'h5850_0000, 1'b0, 5'b0, 32'h0},             // R8
      '{K_WR,  4'd8,  4'd2, 32'h4E4C_0000, 1'b0, 5'b0, 32'h0},             // R8
      '{K_DEC, 4'd11, 4'd0, 32'h2700_0000, 1'b1, 5'b00000, 32'h0},         // R11
      '{K_WR,  4'd6,  4'd1, 32'h5048_0000, 1'b1, 5'b0, 32'h0},             // R6
      '{K_RD,  4'd6,  4'd1, 32'h0,         1'b0, 5'b0, 32'h5048_0000},     // R6
      '{K_DEC, 4'd10, 4'd0, 32'h2680_0000, 1'b0, 5'b00010, 32'h0280_0000}, // R10
      '{K_WR,  4'd7,  4'd2, 32'h4E4C_0000, 1'b0, 5'b0, 32'h0},             // R7
      '{K_RD,  4'd7,  4'd2, 32'h0,         1'b0, 5'b0, 32'h4E4C_0000},     // R7
      '{K_WR,  4'd8,  4'd1, 32'h4C48_0000, 1'b0, 5'b0, 32'h0},             // R8
      '{K_WR,  4'd5,  4'd2, 32'h4F4D_0000, 1'b1, 5'b0, 32'h0},             // R5
      '{K_RD,  4'd5,  4'd2, 32'h0,         1'b0, 5'b0, 32'h4F4D_0000},     // R5
      '{K_DEC, 4'd9,  4'd0, 32'h2680_0000, 1'b0, 5'b00100, 32'h0},         // R9
      '{K_WR,  4'd3,  4'd0, 32'h4830_0000, 1'b1, 5'b0, 32'h0},             // R3
      '{K_RD,  4'd3,  4'd0, 32'h0,         1'b0, 5'b0, 32'h4840_0000},     // R3
      '{K_WR,  4'd8,  4'd0, 32'h4440_0000, 1'b0, 5'b0, 32'h0},             // R8
      '{K_RD,  4'd8,  4'd0, 32'h0,         1'b0, 5'b0, 32'h4440_0000},     // R8
      '{K_DEC, 4'd11, 4'd0, 32'h2200_0000, 1'b1, 5'b00000, 32'h0},         // R11
      '{K_WR,  4'd4,  4'd3, 32'h3830_0000, 1'b1, 5'b0, 32'h0},             // R4
      '{K_RD,  4'd4,  4'd3, 32'h0,         1'b0, 5'b0, 32'h5850_0000},     // R4
      '{K_WR,  4'd4,  4'd3, 32'h7068_0000, 1'b1, 5'b0, 32'h0},             // R4
      '{K_RD,  4'd4,  4'd3, 32'h0,         1'b0, 5'b0, 32'h5850_0000},     // R4
      '{K_WR,  4'd4,  4'd4, 32'h6260_0000, 1'b0, 5'b0, 32'h0},             // R4 edge
      '{K_DEC, 4'd9,  4'd0, 32'h3000_0004, 1'b0, 5'b10000, 32'h0000_0004}, // R9
      '{K_WR,  4'd2,  4'd1, 32'h4C48_ABCD, 1'b0, 5'b0, 32'h0},             // R2
      '{K_RD,  4'd2,  4'd1, 32'h0,         1'b0, 5'b0, 32'h4C48_0000},     // R2
      '{K_WR,  4'd12, 4'd1, 32'h4848_0000, 1'b0, 5'b0, 32'h0},             // R12
      '{K_DEC, 4'd12, 4'd0, 32'h2400_0000, 1'b1, 5'b00000, 32'h0},         // R12
      '{K_WR,  4'd13, 4'd5, 32'h1234_0000, 1'b0, 5'b0, 32'h0},             // R13
      '{K_RD,  4'd13, 4'd5, 32'h0,         1'b0, 5'b0, 32'h0},             // R13
      '{K_RD,  4'd13, 4'd4, 32'h0,         1'b0, 5'b0, 32'h6260_0000}      // R13
   };

   task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_wr(input logic [3:0] idx, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_dec(input logic [31:0] a);
      @(negedge clk);
      vld = 1'b1; addr = a;
      @(negedge clk);
      vld = 1'b0;
   endtask

   task automatic do_rd(input logic [3:0] idx);
      @(negedge clk);
      rd_idx = idx;
      #1;
   endtask

   localparam logic [31:0] DEFS [NCS] = '{32'h4840_0000, 32'h4C48_0000,
      32'h504C_0000, 32'h5450_0000, 32'h5854_0000};

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(1, "err after reset", {31'b0, err}, 32'h0);
      chk(1, "hit after reset", {27'b0, hit}, 32'h0);
      for (int i = 0; i < NCS; i++) begin
         do_rd(4'(i));
         chk(1, "default segment", rd_data, DEFS[i]);
      end

      for (int v = 0; v < NV; v++) begin
         case (VEC[v].kind)
            K_WR: begin
               do_wr(VEC[v].idx, VEC[v].data);
               chk(int'(VEC[v].req), "write err", {31'b0, err}, {31'b0, VEC[v].xerr});
            end
            K_DEC: begin
               do_dec(VEC[v].data);
               chk(int'(VEC[v].req), "hit", {27'b0, hit}, {27'b0, VEC[v].xhit});
               chk(int'(VEC[v].req), "offset", off, VEC[v].xval);
               chk(int'(VEC[v].req), "decode err", {31'b0, err}, {31'b0, VEC[v].xerr});
            end
            default: begin
               do_rd(VEC[v].idx);
               chk(int'(VEC[v].req), "readback", rd_data, VEC[v].xval);
            end
         endcase
      end

      // R9: no qualifier, no hit even on an address inside a segment
      @(negedge clk);
      addr = 32'h3000_0000; vld = 1'b0;
      @(negedge clk);
      chk(9, "hit without valid", {27'b0, hit}, 32'h0);
      // R11: error strobe lasts a single cycle
      do_dec(32'h0000_0000);
      chk(11, "miss err", {31'b0, err}, 32'h1);
      @(negedge clk);
      chk(11, "err one cycle", {31'b0, err}, 32'h0);
      // R1: second reset restores defaults
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      do_rd(4'd4);
      chk(1, "default after re-reset", rd_data, DEFS[4]);
      do_dec(32'h2A00_0008);
      chk(1, "default decode", {27'b0, hit}, 32'h10);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule